// File: doc/BRIEF.md
# Scalable Frame Interval Generator

This block produces the device-side timing of periodic frame and microframe starts. It counts cycles of a fixed-frequency input clock and emits a one-cycle start pulse at the end of each interval. The interval length depends on a 2-bit scale code and a full-speed flag. Each step of the code halves the nominal 125 µs microframe. Full-speed operation stretches the selected interval eightfold. A running counter advances with every start pulse.

For simulation-speed debugging, the same scale code also shrinks the advertised bulk maximum packet size. The block reports that size on a plain output. With debug off, the reported size is always the full 1024 bytes. The clock rate enters through a single parameter, `BASE_CYC`. It is the number of clock cycles in 15.625 µs, the shortest interval, and must be at least 2. Every other interval is an exact power-of-two multiple of it, so fractional microsecond periods need no rounding. All pins are plain control and status signals. No streaming interface is present, so no back-pressure rules apply.

Top module: `frame_interval_gen`

## Requirements
- R1: While `rst_n` is low, and at the first cycle after it, `frame_start` is 0, `frame_cnt` is 0 and `max_pkt` is 1024.
- R2: With `full_speed` low, the interval is `BASE_CYC` × 8 / 2^code cycles. Code 0 gives 8×, code 1 gives 4×, code 2 gives 2× and code 3 gives 1× `BASE_CYC` (125, 62.5, 31.25 and 15.625 µs).
- R3: With `full_speed` high, the interval selected by the code is multiplied by 8.
- R4: `scale_code` and `full_speed` are sampled only at the clock edge that raises `frame_start`, or at the first enabled edge. A change between those edges does not alter the interval in progress.
- R5: With `debug_en` high, `max_pkt` equals 1024 >> code (1024, 512, 256 or 128 bytes). The value appears one clock after the inputs change.
- R6: With `debug_en` low, `max_pkt` is 1024 whatever the code, one clock after the inputs.
- R7: `frame_cnt` rises by exactly one on every `frame_start` pulse, wraps modulo 2^`CNT_W`, and otherwise holds. Its low 3 bits form the microframe index.
- R8: While `enable` is low, no pulse is produced, the interval timer restarts and `frame_cnt` holds. The first pulse comes one full interval after the first enabled edge.
- R9: `frame_start` is high for exactly one cycle per interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed-frequency timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the interval timer when high |
| scale_code | input | 2 | Scale-down code, 0 = no scaling |
| full_speed | input | 1 | High selects the 8× full-speed interval |
| debug_en | input | 1 | High lets the code reduce the packet size |
| frame_start | output | 1 | One-cycle pulse at each interval end |
| frame_cnt | output | CNT_W | Running frame/microframe count |
| max_pkt | output | 11 | Effective bulk maximum packet size in bytes |

## Verification
A wrong timer or a stale latched length shows up as a `frame_start` pulse in the wrong cycle. This is visible no later than the end of the affected interval, at most 64 × `BASE_CYC` cycles. A wrong frame counter shows on `frame_cnt` at the very pulse where it slips. A wrong packet-size state shows on `max_pkt` one clock after the inputs that should set it. Codes are changed in the middle of intervals, and enable is dropped and restored, so that a timer which samples its inputs too early or fails to restart gives a pulse off by at least one cycle.

// File: rtl/fig_pkg.sv
package fig_pkg;
  typedef logic [1:0] scale_t;

  localparam int unsigned PKT_FULL = 1024;
  localparam int unsigned PKT_W    = $clog2(PKT_FULL) + 1;
  localparam int unsigned FS_SHIFT = 3;
  localparam int unsigned MAX_CODE = 3;

  // power-of-two multiple of the 15.625 us base period
  function automatic int unsigned len_shift(scale_t code, logic fs);
    return (MAX_CODE - int'(code)) + (fs ? FS_SHIFT : 0);
  endfunction
endpackage

// File: rtl/fig_len_sel.sv
module fig_len_sel
  import fig_pkg::*;
#(
  parameter int unsigned BASE_CYC = 16,
  parameter int unsigned LEN_W    = 11
) (
  input  scale_t           code,
  input  logic             fs,
  output logic [LEN_W-1:0] len
);
  always_comb begin
    len = LEN_W'(BASE_CYC) << len_shift(code, fs);
  end
endmodule

// File: rtl/fig_timer.sv
module fig_timer #(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LEN_W-1:0] next_len,
  output logic             tick,
  output logic [CNT_W-1:0] frame_cnt
);
  logic             run_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] tmr_q;
  logic [LEN_W-1:0] eff_len;
  logic             at_end;

  // first enabled cycle takes the live length; later cycles keep the latched one
  assign eff_len = run_q ? len_q : next_len;
  assign at_end  = (tmr_q == LEN_W'(eff_len - LEN_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      len_q     <= '0;
      tmr_q     <= '0;
      tick      <= 1'b0;
      frame_cnt <= '0;
    end else if (!enable) begin
      run_q <= 1'b0;
      tmr_q <= '0;
      tick  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (at_end) begin
        tmr_q     <= '0;
        tick      <= 1'b1;
        frame_cnt <= frame_cnt + CNT_W'(1);
        len_q     <= next_len;
      end else begin
        tmr_q <= tmr_q + LEN_W'(1);
        tick  <= 1'b0;
        len_q <= eff_len;
      end
    end
  end

  assert_tmr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (tmr_q < len_q));

  assert_len_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && tmr_q != '0) |-> $stable(len_q));

  assert_tick_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(enable));

  assert_tick_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (frame_cnt == CNT_W'($past(frame_cnt) + CNT_W'(1))));

  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> $stable(frame_cnt));
endmodule

// File: rtl/fig_pkt_sel.sv
module fig_pkt_sel
  import fig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             debug_en,
  input  scale_t           code,
  output logic [PKT_W-1:0] max_pkt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_pkt <= PKT_W'(PKT_FULL);
    end else if (debug_en) begin
      max_pkt <= PKT_W'(PKT_FULL) >> code;
    end else begin
      max_pkt <= PKT_W'(PKT_FULL);
    end
  end

  assert_pkt_pow2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(max_pkt) == 1);

  assert_pkt_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    max_pkt >= PKT_W'(PKT_FULL >> MAX_CODE));

  assert_pkt_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(debug_en) |-> max_pkt == PKT_W'(PKT_FULL));
endmodule

// File: rtl/frame_interval_gen.sv
module frame_interval_gen
  import fig_pkg::*;
#(
  parameter int unsigned BASE_CYC = 16,
  parameter int unsigned CNT_W    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       scale_code,
  input  logic             full_speed,
  input  logic             debug_en,
  output logic             frame_start,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [10:0]      max_pkt
);
  localparam int unsigned MAX_MULT = 1 << (MAX_CODE + FS_SHIFT);
  localparam int unsigned LEN_W    = $clog2(BASE_CYC * MAX_MULT) + 1;

  logic [LEN_W-1:0] next_len;

  fig_len_sel #(.BASE_CYC(BASE_CYC), .LEN_W(LEN_W)) i_len (
    .code (scale_code),
    .fs   (full_speed),
    .len  (next_len)
  );

  fig_timer #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .next_len  (next_len),
    .tick      (frame_start),
    .frame_cnt (frame_cnt)
  );

  fig_pkt_sel i_pkt (
    .clk      (clk),
    .rst_n    (rst_n),
    .debug_en (debug_en),
    .code     (scale_code),
    .max_pkt  (max_pkt)
  );
endmodule

// File: tb/test_frame_interval_gen.sv
module test_frame_interval_gen;
  localparam int BASE = 16;
  localparam int CW   = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic [1:0]    code;
  logic          fs;
  logic          dbg;
  logic          fstart;
  logic [CW-1:0] fcnt;
  logic [10:0]   mpkt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference state
  bit       m_run = 1'b0;
  int       m_t   = 0;
  int       m_len = 0;
  int       m_fc  = 0;
  logic [1:0] m_code;
  logic     m_fs;
  bit       prev_fs = 1'b0;

  always #5 clk = ~clk;

  frame_interval_gen #(.BASE_CYC(BASE), .CNT_W(CW)) i_frame_interval_gen (
    .clk(clk), .rst_n(rst_n), .enable(en), .scale_code(code),
    .full_speed(fs), .debug_en(dbg), .frame_start(fstart),
    .frame_cnt(fcnt), .max_pkt(mpkt)
  );

  function automatic int exp_len(logic [1:0] c, logic f);
    int l = BASE * 8;
    for (int i = 0; i < int'(c); i++) l = l / 2;
    if (f) l = l * 8;
    return l;
  endfunction

  function automatic int exp_pkt(logic d, logic [1:0] c);
    if (!d) return 1024;
    case (c)
      2'd0: return 1024;
      2'd1: return 512;
      2'd2: return 256;
      default: return 128;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: model the edge just passed with the inputs applied to it
  task automatic step();
    bit    ep;
    string tag;
    @(negedge clk);
    ep  = 1'b0;
    tag = "R8";
    if (en) begin
      if (!m_run) begin
        m_run = 1'b1; m_t = 0;
        m_len = exp_len(code, fs); m_code = code; m_fs = fs;
      end
      ep = (m_t == m_len - 1);
      if (code != m_code || fs != m_fs) tag = "R4";
      else if (m_fs) tag = "R3";
      else tag = "R2";
      if (ep) begin
        m_t = 0; m_fc++;
        m_len = exp_len(code, fs); m_code = code; m_fs = fs;
      end else begin
        m_t++;
      end
    end else begin
      m_run = 1'b0; m_t = 0;
    end
    if (ep || fstart) chk(fstart == ep, tag, int'(fstart), int'(ep));
    if (fstart && prev_fs) chk(1'b0, "R9", 1, 0);
    if (ep) chk(fcnt == CW'(m_fc), "R7", int'(fcnt), m_fc % (1 << CW));
    else if (m_t % 8 == 0) chk(fcnt == CW'(m_fc), en ? "R7" : "R8", int'(fcnt), m_fc % (1 << CW));
    chk(int'(mpkt) == exp_pkt(dbg, code), dbg ? "R5" : "R6", int'(mpkt), exp_pkt(dbg, code));
    prev_fs = fstart;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; en = 1'b0; code = 2'd0; fs = 1'b0; dbg = 1'b0;
    repeat (3) @(negedge clk);
    chk(fstart == 1'b0, "R1", int'(fstart), 0);
    chk(fcnt == '0, "R1", int'(fcnt), 0);
    chk(mpkt == 11'd1024, "R1", int'(mpkt), 1024);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fstart == 1'b0 && fcnt == '0 && mpkt == 11'd1024, "R1", int'(fcnt), 0);

    // disabled: nothing happens (R8)
    run(40);
    // high-speed codes, switched mid-interval (R2, R4)
    en = 1'b1; code = 2'd0;
    run(300);
    code = 2'd1; run(200);
    code = 2'd2; run(150);
    code = 2'd3; run(100);
    // full-speed (R3)
    fs = 1'b1; run(300);
    code = 2'd0; run(2200);
    // debug packet sizes (R5, R6)
    dbg = 1'b1;
    for (int c = 0; c < 4; c++) begin code = 2'(c); run(3); end
    dbg = 1'b0; code = 2'd3; run(3);
    // counter wrap with the shortest interval (R7)
    fs = 1'b0; dbg = 1'b1;
    run(16 * 80);
    // enable dropped and restored mid-interval (R8)
    run(7); en = 1'b0; run(10); code = 2'd2; en = 1'b1; run(100);
    // constrained random mix
    for (int i = 0; i < 60000; i++) begin
      int unsigned r = $urandom;
      if (r % 150 == 0) code = 2'($urandom);
      if (r % 401 == 1) fs = ~fs;
      if (r % 60 == 2) dbg = ~dbg;
      if (r % 2500 == 3) en = ~en;
      step();
    end
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule